// File: doc/BRIEF.md
# Three-Master Preemptive Bus Arbiter

This block shares one system bus among three masters ranked by fixed priority. The RAM-FIFO engine ranks highest, the transfer controller is in the middle, and the CPU ranks lowest. The CPU holds the bus whenever nobody else wants it. A request from a higher-ranked master never takes the bus at once. It waits until the current owner reaches a point where a handover is allowed, and which points are allowed depends on both the owner and the requester.

Each owner reports its progress on the bus. A boundary input pulses at the end of a bus cycle. A lock input, sampled together with the boundary, marks that boundary as falling inside an indivisible sequence. Such a sequence is either the halves of a split longword access or the chain of longword cycles in a 32-bit transfer. The RAM-FIFO engine gives the bus back only by pulsing a done input. A CPU sleep input lifts every boundary rule while the CPU owns the bus.

Grants are registered and one-hot. Every handover passes through exactly one cycle in which no grant is active.

Top module: `bus_arbiter3`

## Requirements
- R1: While reset is active and in the first cycle after it, `gnt_cpu` is 1 and `gnt_xfer` and `gnt_fifo` are 0. The bench reads the grants as a vector {cpu, xfer, fifo}, so the reset value is 100.
- R2: At most one grant is high in any cycle. Every change of owner goes through exactly one cycle with all grants low, and the new grant rises in the next cycle.
- R3: The CPU owns the bus, the CPU is awake and the RAM-FIFO engine is not requesting. A transfer-controller request is then taken only on a clock edge where `cpu_edge`=1 and `cpu_lock`=0. With `cpu_edge`=0, or with `cpu_lock`=1, the CPU keeps the bus.
- R4: The CPU owns the bus. A RAM-FIFO request is then taken on any edge with `cpu_edge`=1, whatever the value of `cpu_lock`.
- R5: The CPU owns the bus and `cpu_sleep`=1. A request from either other master is then taken on the next edge, with no boundary needed.
- R6: The transfer controller owns the bus and keeps requesting. A RAM-FIFO request is then taken only on an edge with `xfer_edge`=1 and `xfer_lock`=0. The transfer controller keeps the bus at every boundary inside a split access and at every boundary between the longword cycles of a 32-bit transfer.
- R7: Once the RAM-FIFO engine owns the bus, it keeps the bus on every edge where `fifo_done`=0. This holds whatever the other requests, boundaries or `cpu_sleep` are doing.
- R8: An edge with `fifo_done`=1 starts a handover. The bus goes to the transfer controller if `xfer_req`=1 on that edge, and to the CPU otherwise.
- R9: The CPU owns the bus and both other masters request on an allowed edge. The RAM-FIFO engine then wins.
- R10: When the transfer controller owns the bus and drops `xfer_req`, it gives up the bus on that edge. The bus goes to the RAM-FIFO engine if `fifo_req`=1, and to the CPU otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sleep | input | 1 | CPU is asleep: handover from the CPU needs no boundary |
| cpu_edge | input | 1 | The CPU's current bus cycle ends at this edge |
| cpu_lock | input | 1 | This CPU boundary falls inside a split access |
| xfer_req | input | 1 | Bus request from the transfer controller |
| xfer_edge | input | 1 | The transfer controller's bus cycle ends at this edge |
| xfer_lock | input | 1 | This transfer-controller boundary falls inside a split access or a 32-bit chain |
| fifo_req | input | 1 | Bus request from the RAM-FIFO engine |
| fifo_done | input | 1 | The RAM-FIFO engine has finished its whole operation |
| gnt_cpu | output | 1 | Bus granted to the CPU |
| gnt_xfer | output | 1 | Bus granted to the transfer controller |
| gnt_fifo | output | 1 | Bus granted to the RAM-FIFO engine |

## Verification
The bound checker watches the fixed rules on every cycle. It confirms that no two grants are ever high together and that a no-grant cycle always ends after one cycle. It also confirms that the CPU holds on to the bus against the transfer controller off an allowed boundary, that the transfer controller holds against the RAM-FIFO engine inside locked sequences, that the RAM-FIFO engine holds until done, and that sleep or a RAM-FIFO request at any CPU boundary forces a release.

The scoreboarded scenarios are the only place where a handover is seen to land on the right master after its gap cycle. They cover who follows the RAM-FIFO engine on release, priority when two masters request at once, the reset value, and the exact edge at which each locked or unlocked boundary is honoured.

// File: rtl/bus_arbiter3.sv
module bus_arbiter3 (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_sleep,
  input  logic cpu_edge,
  input  logic cpu_lock,
  input  logic xfer_req,
  input  logic xfer_edge,
  input  logic xfer_lock,
  input  logic fifo_req,
  input  logic fifo_done,
  output logic gnt_cpu,
  output logic gnt_xfer,
  output logic gnt_fifo
);
  typedef enum logic [1:0] {OW_CPU, OW_XFER, OW_FIFO, OW_GAP} owner_t;

  owner_t own_q, own_d, tgt_q, tgt_d;

  wire cpu_free_any  = cpu_sleep | cpu_edge;
  wire cpu_free_full = cpu_sleep | (cpu_edge & ~cpu_lock);
  wire xfer_free     = xfer_edge & ~xfer_lock;

  always_comb begin
    own_d = own_q;
    tgt_d = tgt_q;
    unique case (own_q)
      OW_CPU: begin
        if (fifo_req && cpu_free_any) begin
          own_d = OW_GAP; tgt_d = OW_FIFO;
        end else if (xfer_req && cpu_free_full) begin
          own_d = OW_GAP; tgt_d = OW_XFER;
        end
      end
      OW_XFER: begin
        if (!xfer_req || (fifo_req && xfer_free)) begin
          own_d = OW_GAP; tgt_d = fifo_req ? OW_FIFO : OW_CPU;
        end
      end
      OW_FIFO: begin
        if (fifo_done) begin
          own_d = OW_GAP; tgt_d = xfer_req ? OW_XFER : OW_CPU;
        end
      end
      default: own_d = tgt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OW_CPU;
      tgt_q <= OW_CPU;
    end else begin
      own_q <= own_d;
      tgt_q <= tgt_d;
    end
  end

  assign gnt_cpu  = (own_q == OW_CPU);
  assign gnt_xfer = (own_q == OW_XFER);
  assign gnt_fifo = (own_q == OW_FIFO);
endmodule

module bus_arbiter3_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_sleep,
  input logic cpu_edge,
  input logic cpu_lock,
  input logic xfer_req,
  input logic xfer_edge,
  input logic xfer_lock,
  input logic fifo_req,
  input logic fifo_done,
  input logic gnt_cpu,
  input logic gnt_xfer,
  input logic gnt_fifo
);
  wire [2:0] g = {gnt_cpu, gnt_xfer, gnt_fifo};

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(g) <= 1); // R2
  AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (g == 3'b000) |=> (g != 3'b000)); // R2
  AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_cpu && !cpu_sleep && !fifo_req && !(cpu_edge && !cpu_lock)) |=> gnt_cpu); // R3
  AST_FIFO_SPLITS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_cpu && fifo_req && cpu_edge) |=> (g == 3'b000)); // R4
  AST_SLEEP_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_cpu && cpu_sleep && (xfer_req || fifo_req)) |=> !gnt_cpu); // R5
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_xfer && xfer_req && !(xfer_edge && !xfer_lock)) |=> gnt_xfer); // R6
  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_fifo && !fifo_done) |=> gnt_fifo); // R7
endmodule

bind bus_arbiter3 bus_arbiter3_chk chk (
  .clk(clk), .rst_n(rst_n), .cpu_sleep(cpu_sleep), .cpu_edge(cpu_edge),
  .cpu_lock(cpu_lock), .xfer_req(xfer_req), .xfer_edge(xfer_edge),
  .xfer_lock(xfer_lock), .fifo_req(fifo_req), .fifo_done(fifo_done),
  .gnt_cpu(gnt_cpu), .gnt_xfer(gnt_xfer), .gnt_fifo(gnt_fifo)
);

// File: tb/bus_arbiter3_test.sv
module bus_arbiter3_test;
  logic clk = 0, rst_n = 0;
  logic cpu_sleep = 0, cpu_edge = 0, cpu_lock = 0;
  logic xfer_req = 0, xfer_edge = 0, xfer_lock = 0;
  logic fifo_req = 0, fifo_done = 0;
  logic gnt_cpu, gnt_xfer, gnt_fifo;

  localparam logic [2:0] GC = 3'b100, GX = 3'b010, GF = 3'b001, GN = 3'b000;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  bus_arbiter3 uut (
    .clk(clk), .rst_n(rst_n), .cpu_sleep(cpu_sleep), .cpu_edge(cpu_edge),
    .cpu_lock(cpu_lock), .xfer_req(xfer_req), .xfer_edge(xfer_edge),
    .xfer_lock(xfer_lock), .fifo_req(fifo_req), .fifo_done(fifo_done),
    .gnt_cpu(gnt_cpu), .gnt_xfer(gnt_xfer), .gnt_fifo(gnt_fifo)
  );

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grants actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] exp, input string tag);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q_exp.size() > 0)
      check({gnt_cpu, gnt_xfer, gnt_fifo}, q_exp.pop_front(), q_tag.pop_front());
  end

  initial begin
    repeat (3) @(negedge clk);
    check({gnt_cpu, gnt_xfer, gnt_fifo}, GC, "R1 in reset");
    rst_n = 1;
    cyc(GC, "R1 after reset");

    xfer_req = 1;                                 cyc(GC, "R3 no boundary");
    cpu_edge = 1; cpu_lock = 1;                   cyc(GC, "R3 split boundary");
    cpu_lock = 0;                                 cyc(GN, "R3 R2 gap");
    cpu_edge = 0;                                 cyc(GX, "R3 handover");

    fifo_req = 1;                                 cyc(GX, "R6 no boundary");
    xfer_edge = 1; xfer_lock = 1;                 cyc(GX, "R6 longword chain");
    xfer_lock = 0;                                cyc(GN, "R6 R2 gap");
    xfer_edge = 0;                                cyc(GF, "R6 handover");

    fifo_req = 0; cpu_edge = 1; cpu_sleep = 1;    cyc(GF, "R7 hold a");
    xfer_edge = 1; cpu_sleep = 0;                 cyc(GF, "R7 hold b");
    cpu_edge = 0; xfer_edge = 0;                  cyc(GF, "R7 hold c");
    fifo_done = 1;                                cyc(GN, "R8 gap");
    fifo_done = 0;                                cyc(GX, "R8 to xfer");

    xfer_req = 0;                                 cyc(GN, "R10 gap");
                                                  cyc(GC, "R10 to cpu");

    fifo_req = 1; cpu_edge = 1; cpu_lock = 1;     cyc(GN, "R4 split boundary");
    cpu_edge = 0; cpu_lock = 0;                   cyc(GF, "R4 handover");
    fifo_req = 0; fifo_done = 1;                  cyc(GN, "R8 gap cpu");
    fifo_done = 0;                                cyc(GC, "R8 to cpu");

    cpu_sleep = 1; xfer_req = 1;                  cyc(GN, "R5 xfer gap");
                                                  cyc(GX, "R5 xfer granted");
    xfer_req = 0; cpu_sleep = 0;                  cyc(GN, "R10 release");
                                                  cyc(GC, "R10 cpu back");
    cpu_sleep = 1; fifo_req = 1;                  cyc(GN, "R5 fifo gap");
                                                  cyc(GF, "R5 fifo granted");
    cpu_sleep = 0; fifo_req = 0; fifo_done = 1;   cyc(GN, "R8 gap");
    fifo_done = 0;                                cyc(GC, "R8 cpu");

    xfer_req = 1; fifo_req = 1; cpu_edge = 1;     cyc(GN, "R9 gap");
    cpu_edge = 0;                                 cyc(GF, "R9 fifo wins");
    fifo_req = 0; fifo_done = 1;                  cyc(GN, "R8 gap");
    fifo_done = 0;                                cyc(GX, "R8 xfer waited");
    fifo_req = 1; xfer_req = 0;                   cyc(GN, "R10 release with fifo");
    fifo_req = 0;                                 cyc(GF, "R10 to fifo");
    fifo_done = 1;                                cyc(GN, "R8 gap");
    fifo_done = 0;                                cyc(GC, "R8 idle cpu");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule